// File: doc/BRIEF.md
# RGB Pixel Bus Formatter

The formatter sits between a pixel word FIFO and the parallel data pins of an LCD panel. It takes 32-bit words over a valid/ready interface and, for every pixel-clock enable, places one beat on a 24-bit data bus. Each beat is carried by a registered strobe. Static configuration pins set how a word is unpacked. These are a pixel word length (16-bit RGB565 packed two per word, or 24-bit colour held one per 32-bit word), a panel bus width (8, 16, 18 or 24 bits), a reduction flag that keeps only the low six bits of each 8-bit component, and a 4-bit byte-valid mask.

A single word register holds the word being unpacked. Back-pressure rules on the word side are as follows. `word_ready` is high whenever that register is empty. It is also high in the cycle that sends the last beat of the held word, so a new word can replace it in the same cycle. The data on `word_data` is taken on a rising edge where `word_valid` and `word_ready` are both high. An unfinished word is never overwritten. A beat that is due while no word is held is sent as zero and sets a sticky underflow flag. A clear input drops the held word, resets the unpack position and clears that flag. Configuration is only changed together with a clear.

Top module: `rgb_bus_formatter`

## Requirements
- R1: After reset, `pix_strobe`, `pix_data` and `underflow` are zero, and `word_ready` is high.
- R2: `word_ready` is high only when no word is held, or when the last beat of the held word is being sent in this cycle with no configuration error. While a word still has beats left to send, no new word is taken.
- R3: With word length code 0 on the 16-bit bus (bus code 1), each word gives two beats: bits 15:0 first and then bits 31:16. Each is placed unchanged on `pix_data[15:0]`, and bits 23:16 are zero.
- R4: With word length code 0 on the 8-bit bus (bus code 0), each word gives four beats on `pix_data[7:0]` in this order: bits 15:8, 7:0, 31:24, 23:16.
- R5: With word length code 0 on the 18-bit bus (bus code 2), a pixel with red in bits 15:11, green in 10:5 and blue in 4:0 is sent as {r,r[4]} on bits 17:12, g on bits 11:6 and {b,b[4]} on bits 5:0.
- R6: With word length code 0 on the 24-bit bus (bus code 3), the pixel is sent as {r,r[4:2]} on bits 23:16, {g,g[5:4]} on bits 15:8 and {b,b[4:2]} on bits 7:0.
- R7: With word length code 3 on the 24-bit bus, each word gives one beat equal to word bits 23:0. The top byte and mask bit 3 are ignored. When mask bit 2, 1 or 0 is clear, the red (23:16), green (15:8) or blue (7:0) component is sent as zero.
- R8: With word length code 3, a 16- or 18-bit bus and the reduction flag set, the beat is {R[5:0],G[5:0],B[5:0]} on bits 17:0, with the mask gating as in R7.
- R9: With word length code 3, a 16- or 18-bit bus and the reduction flag clear, the beat is {R[7:2],G[7:2],B[7:2]} on bits 17:0.
- R10: `cfg_error` is high for word length codes 1 and 2, for code 3 with the 8-bit bus, and for code 0 with a mask other than 4'hF. While it is high, pixel enables produce no strobe.
- R11: A pixel enable with no word held gives a strobe with zero data in the next cycle. It also sets `underflow`, which stays set until a clear or a reset.
- R12: While `fifo_clear` is high, `word_ready` is low and pixel enables are ignored. After a clear, the held word is gone and unpacking starts at the first beat of the next word taken.
- R13: `pix_strobe` is high exactly in the cycle after a pixel enable that was given with no clear and no configuration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clear | input | 1 | Drops the held word, resets the unpack position, clears underflow |
| cfg_word_len | input | 2 | Pixel word length: 0 = RGB565 two per word, 3 = 24-bit one per word |
| cfg_bus_width | input | 2 | Panel bus: 0 = 8, 1 = 16, 2 = 18, 3 = 24 bits |
| cfg_reduce | input | 1 | Keep the low six bits of each 8-bit component |
| cfg_byte_mask | input | 4 | Byte-valid mask of the input word |
| word_valid | input | 1 | Word available on `word_data` |
| word_ready | output | 1 | Formatter takes the word on this edge |
| word_data | input | 32 | Input pixel word |
| pix_en | input | 1 | Pixel-clock enable: one beat is due |
| pix_strobe | output | 1 | `pix_data` carries a new beat |
| pix_data | output | 24 | Panel data bus |
| cfg_error | output | 1 | Unsupported configuration |
| underflow | output | 1 | Sticky: a beat was due with no word held |

## Verification
A held word that goes stale or is lost shows up on the next enabled beat. It gives either a wrong value on `pix_data` or an underflow that should not happen. A wrong unpack position gives a half-word or byte in the wrong order within the next two to four beats of a 16-bit word. A held-state flag that is wrong shows up on `word_ready` in the same cycle, because the bench predicts ready from its own count of the beats still to be sent. A wrong error or sticky flag is seen one cycle after the enable that should have set it, or after the clear that should have reset it.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;
  localparam int HALF_W = WORD_W / 2;
  localparam int COMP_W = 8;
  localparam int NCOMP  = 3;
  localparam int NARR_W = 6;
  localparam int MASK_W = WORD_W / 8;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = IDX_W + 1;

  localparam logic [1:0] WL_16  = 2'd0;
  localparam logic [1:0] WL_32  = 2'd3;
  localparam logic [1:0] BUS_8  = 2'd0;
  localparam logic [1:0] BUS_16 = 2'd1;
  localparam logic [1:0] BUS_18 = 2'd2;
  localparam logic [1:0] BUS_24 = 2'd3;

  function automatic logic cfg_bad(input logic [1:0] wl, input logic [1:0] bw,
                                   input logic [MASK_W-1:0] mask);
    logic bad;
    bad = 1'b0;
    if (wl != WL_16 && wl != WL_32) bad = 1'b1;
    if (wl == WL_32 && bw == BUS_8) bad = 1'b1;
    if (wl == WL_16 && mask != {MASK_W{1'b1}}) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic [CNT_W-1:0] beats_for(input logic [1:0] wl, input logic [1:0] bw);
    if (wl == WL_16) return (bw == BUS_8) ? CNT_W'(4) : CNT_W'(2);
    return CNT_W'(1);
  endfunction
endpackage

// File: rtl/rbf_word_hold.sv
module rbf_word_hold #(
  parameter int W = rbf_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  assign in_ready = !clear && (!full || take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (clear) begin
      full <= 1'b0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R2: a held word with beats left is neither replaced nor dropped
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && !clear) |=> (full && $stable(data)));
endmodule

// File: rtl/rbf_beat_ctr.sv
module rbf_beat_ctr #(
  parameter int IDX_W = rbf_pkg::IDX_W,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [CNT_W-1:0] beats,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  assign last = ({1'b0, idx} == (beats - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (clear)  idx <= '0;
    else if (adv)    idx <= last ? '0 : idx + IDX_W'(1);
  end

  // R3: after the final beat of a word the position returns to the first beat
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last && !clear) |=> (idx == '0));

  // R12: a clear always restarts at the first beat
  p_clear_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (idx == '0));
endmodule

// File: rtl/rbf_pixel_map.sv
module rbf_pixel_map
  import rbf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        wl,
  input  logic [1:0]        bw,
  input  logic              reduce,
  input  logic [NCOMP-1:0]  comp_en,
  output logic [PIX_W-1:0]  beat
);
  // 24-bit source path: gate, then narrow each component
  logic [COMP_W-1:0] comp8 [NCOMP];
  logic [NARR_W-1:0] comp6 [NCOMP];

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    assign comp8[c] = comp_en[c] ? word[c*COMP_W +: COMP_W] : '0;
    assign comp6[c] = reduce ? comp8[c][NARR_W-1:0]
                             : comp8[c][COMP_W-1:COMP_W-NARR_W];
  end

  logic [PIX_W-1:0] full24, narrow18;
  assign full24   = {comp8[2], comp8[1], comp8[0]};
  assign narrow18 = {{(PIX_W-3*NARR_W){1'b0}}, comp6[2], comp6[1], comp6[0]};

  // RGB565 source path
  logic              upper_half;
  logic [HALF_W-1:0] px;
  logic [4:0]        r5, b5;
  logic [5:0]        g6;

  assign upper_half = (bw == BUS_8) ? idx[1] : idx[0];
  assign px = upper_half ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
  assign r5 = px[15:11];
  assign g6 = px[10:5];
  assign b5 = px[4:0];

  logic [PIX_W-1:0] p565;
  always_comb begin
    unique case (bw)
      BUS_8:   p565 = {16'h0, (idx[0] ? px[7:0] : px[15:8])};
      BUS_16:  p565 = {8'h0, px};
      BUS_18:  p565 = {6'h0, r5, r5[4], g6, b5, b5[4]};
      default: p565 = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
    endcase
  end

  always_comb begin
    if (wl == WL_16)        beat = p565;
    else if (bw == BUS_24)  beat = full24;
    else if (bw == BUS_8)   beat = '0;
    else                    beat = narrow18;
  end
endmodule

// File: rtl/rgb_bus_formatter.sv
module rgb_bus_formatter
  import rbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clear,
  input  logic [1:0]        cfg_word_len,
  input  logic [1:0]        cfg_bus_width,
  input  logic              cfg_reduce,
  input  logic [MASK_W-1:0] cfg_byte_mask,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic              pix_en,
  output logic              pix_strobe,
  output logic [PIX_W-1:0]  pix_data,
  output logic              cfg_error,
  output logic              underflow
);
  logic              hold_full, last_beat, beat_go, take, adv;
  logic [WORD_W-1:0] hold_data;
  logic [IDX_W-1:0]  beat_idx;
  logic [CNT_W-1:0]  beats;
  logic [PIX_W-1:0]  beat_val;

  assign cfg_error = cfg_bad(cfg_word_len, cfg_bus_width, cfg_byte_mask);
  assign beats     = beats_for(cfg_word_len, cfg_bus_width);
  assign beat_go   = pix_en && !cfg_error && !fifo_clear;
  assign adv       = beat_go && hold_full;
  assign take      = adv && last_beat;

  rbf_word_hold #(.W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (fifo_clear),
    .in_valid (word_valid),
    .in_ready (word_ready),
    .in_data  (word_data),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  rbf_beat_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fifo_clear),
    .adv   (adv),
    .beats (beats),
    .idx   (beat_idx),
    .last  (last_beat)
  );

  rbf_pixel_map u_map (
    .word    (hold_data),
    .idx     (beat_idx),
    .wl      (cfg_word_len),
    .bw      (cfg_bus_width),
    .reduce  (cfg_reduce),
    .comp_en (cfg_byte_mask[NCOMP-1:0]),
    .beat    (beat_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_strobe <= 1'b0;
      pix_data   <= '0;
      underflow  <= 1'b0;
    end else if (fifo_clear) begin
      pix_strobe <= 1'b0;
      underflow  <= 1'b0;
    end else if (beat_go) begin
      pix_strobe <= 1'b1;
      pix_data   <= hold_full ? beat_val : '0;
      if (!hold_full) underflow <= 1'b1;
    end else begin
      pix_strobe <= 1'b0;
    end
  end

  // R10: an unsupported setting never produces a beat
  p_error_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && cfg_error) |=> !pix_strobe);

  // R11: a due beat with nothing held goes out as zero and flags underflow
  p_underflow_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !cfg_error && !fifo_clear && !hold_full) |=>
      (pix_strobe && pix_data == '0 && underflow));

  // R11: the underflow flag holds until a clear
  p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !fifo_clear) |=> underflow);

  // R13: every strobe follows an enable given without a clear
  p_strobe_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> $past(pix_en && !fifo_clear));

  // R12: a clear leaves nothing held and emits nothing
  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (!hold_full && !pix_strobe && !underflow));
endmodule

// File: tb/rgb_bus_formatter_bench.sv
module rgb_bus_formatter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_clear = 1'b0;
  logic [1:0]  cfg_word_len = 2'd0;
  logic [1:0]  cfg_bus_width = 2'd1;
  logic        cfg_reduce = 1'b0;
  logic [3:0]  cfg_byte_mask = 4'hF;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [31:0] word_data = '0;
  logic        pix_en = 1'b0;
  logic        pix_strobe;
  logic [23:0] pix_data;
  logic        cfg_error;
  logic        underflow;

  always #10 clk = ~clk;

  rgb_bus_formatter u_rgb_bus_formatter (
    .clk(clk), .rst_n(rst_n), .fifo_clear(fifo_clear),
    .cfg_word_len(cfg_word_len), .cfg_bus_width(cfg_bus_width),
    .cfg_reduce(cfg_reduce), .cfg_byte_mask(cfg_byte_mask),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .pix_en(pix_en), .pix_strobe(pix_strobe), .pix_data(pix_data),
    .cfg_error(cfg_error), .underflow(underflow)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [23:0] q[$];
  bit          exp_strobe = 1'b0;
  bit          exp_uf = 1'b0;
  logic [23:0] exp_data = '0;
  string       exp_req = "R13";
  logic [1:0]  nwl = 2'd0, nbw = 2'd1;
  logic        nred = 1'b0;
  logic [3:0]  nmsk = 4'hF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_err(input logic [1:0] wl, input logic [1:0] bw, input logic [3:0] m);
    return (wl == 2'd1) || (wl == 2'd2) || (wl == 2'd3 && bw == 2'd0) || (wl == 2'd0 && m != 4'hF);
  endfunction

  function automatic int ref_beats(input logic [1:0] wl, input logic [1:0] bw);
    if (wl == 2'd0) return (bw == 2'd0) ? 4 : 2;
    return 1;
  endfunction

  function automatic string req_of(input logic [1:0] wl, input logic [1:0] bw, input logic red);
    if (wl == 2'd0) begin
      case (bw)
        2'd0: return "R4";
        2'd1: return "R3";
        2'd2: return "R5";
        default: return "R6";
      endcase
    end
    if (bw == 2'd3) return "R7";
    return red ? "R8" : "R9";
  endfunction

  function automatic logic [23:0] ref_beat(input logic [31:0] w, input int i, input logic [1:0] wl,
                                           input logic [1:0] bw, input logic red, input logic [3:0] m);
    int p, r, g, b, half;
    if (wl == 2'd0) begin
      half = (bw == 2'd0) ? i / 2 : i;
      p = int'((w >> (16 * half)) & 32'hFFFF);
      r = p >> 11; g = (p >> 5) & 63; b = p & 31;
      case (bw)
        2'd0: return 24'((i % 2 == 0) ? (p >> 8) : (p & 255));
        2'd1: return 24'(p);
        2'd2: return 24'((((r << 1) | (r >> 4)) << 12) | (g << 6) | ((b << 1) | (b >> 4)));
        default: return 24'((((r << 3) | (r >> 2)) << 16) | (((g << 2) | (g >> 4)) << 8) | ((b << 3) | (b >> 2)));
      endcase
    end
    r = m[2] ? int'((w >> 16) & 255) : 0;
    g = m[1] ? int'((w >> 8) & 255) : 0;
    b = m[0] ? int'(w & 255) : 0;
    if (bw == 2'd3) return 24'((r << 16) | (g << 8) | b);
    if (red) return 24'(((r & 63) << 12) | ((g & 63) << 6) | (b & 63));
    return 24'(((r >> 2) << 12) | ((g >> 2) << 6) | (b >> 2));
  endfunction

  task automatic step(input logic pe, input logic v, input logic [31:0] d, input logic clr);
    bit e, rdy_exp;
    @(negedge clk);
    // results of the previous edge
    chk(pix_strobe === exp_strobe, "R13", {31'b0, pix_strobe}, {31'b0, exp_strobe});
    if (exp_strobe && pix_strobe)
      chk(pix_data === exp_data, exp_req, {8'b0, pix_data}, {8'b0, exp_data});
    chk(underflow === exp_uf, "R11", {31'b0, underflow}, {31'b0, exp_uf});
    chk(cfg_error === ref_err(cfg_word_len, cfg_bus_width, cfg_byte_mask), "R10",
        {31'b0, cfg_error}, {31'b0, ref_err(cfg_word_len, cfg_bus_width, cfg_byte_mask)});
    // drive the next cycle
    cfg_word_len = nwl; cfg_bus_width = nbw; cfg_reduce = nred; cfg_byte_mask = nmsk;
    pix_en = pe; word_valid = v; word_data = d; fifo_clear = clr;
    #5;
    e = ref_err(nwl, nbw, nmsk);
    rdy_exp = !clr && (q.size() == 0 || (pe && !e && q.size() == 1));
    chk(word_ready === rdy_exp, clr ? "R12" : "R2", {31'b0, word_ready}, {31'b0, rdy_exp});
    exp_strobe = pe && !clr && !e;
    if (clr) begin
      q.delete();
      exp_uf = 1'b0;
    end else if (exp_strobe) begin
      if (q.size() == 0) begin
        exp_data = '0; exp_uf = 1'b1; exp_req = "R11";
      end else begin
        exp_data = q.pop_front(); exp_req = req_of(nwl, nbw, nred);
      end
    end
    if (v && word_ready)
      for (int i = 0; i < ref_beats(nwl, nbw); i++) q.push_back(ref_beat(d, i, nwl, nbw, nred, nmsk));
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic [1:0] bw, input logic red, input logic [3:0] m);
    nwl = wl; nbw = bw; nred = red; nmsk = m;
    step(1'b0, 1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pix_strobe === 1'b0, "R1", {31'b0, pix_strobe}, 32'h0);
    chk(pix_data === 24'h0, "R1", {8'b0, pix_data}, 32'h0);
    chk(underflow === 1'b0, "R1", {31'b0, underflow}, 32'h0);
    chk(word_ready === 1'b1, "R1", {31'b0, word_ready}, 32'h1);

    // R11: beat due with nothing held, then sticky, then cleared
    step(1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b0);
    set_cfg(2'd0, 2'd1, 1'b0, 4'hF);

    // R12 and R2: partial word dropped by a clear
    step(1'b0, 1'b1, 32'h1111_2222, 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b1, 32'h5555_6666, 1'b0);
    step(1'b0, 1'b1, 32'h7777_8888, 1'b1);
    step(1'b0, 1'b1, 32'hABCD_1234, 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b0);

    // R4: byte order on the narrow bus
    set_cfg(2'd0, 2'd0, 1'b0, 4'hF);
    step(1'b0, 1'b1, 32'h1234_ABCD, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 32'h0, 1'b0);

    // R10: unsupported settings stay silent
    set_cfg(2'd1, 2'd3, 1'b0, 4'hF);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    set_cfg(2'd3, 2'd0, 1'b1, 4'h7);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    set_cfg(2'd0, 2'd1, 1'b0, 4'hE);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    set_cfg(2'd2, 2'd2, 1'b0, 4'h7);
    step(1'b1, 1'b0, 32'h0, 1'b0);

    // R7: mask gating with extremes
    set_cfg(2'd3, 2'd3, 1'b0, 4'h5);
    step(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 1'b1, 32'hFF00_0000, 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);

    // random segments over every supported combination
    for (int s = 0; s < 12; s++) begin
      int c;
      c = $urandom_range(0, 6);
      if (c < 4) set_cfg(2'(c), 2'(c), 1'b0, 4'hF);
      else set_cfg(2'd3, 2'(c - 3), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
      if (c < 4) begin
        nwl = 2'd0;
      end
      step(1'b0, 1'b1, $urandom, 1'b0);
      for (int k = 0; k < 120; k++) step($urandom_range(0, 2) != 0, 1'b1, $urandom, 1'b0);
    end
    step(1'b0, 1'b0, 32'h0, 1'b1);
    step(1'b0, 1'b0, 32'h0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule